// File: doc/BRIEF.md
# Two-Way Tree Switch with Occupancy Arbitration

This block is one switching node of a tree-shaped overlay network. Two packet streams arrive, each into its own small queue. A packet is a single flit: a destination address and a payload. The packet at the head of each queue is steered to one of two outgoing streams. The choice depends on one bit of its destination address, and which bit a node looks at is fixed per instance by a parameter. Each tree level of a larger network therefore uses a different bit.

When both queue heads want the same outgoing stream in one cycle, the queue that holds more packets is served. A tie goes to input 0. Each outgoing stream is held in a register stage with a valid/ready handshake. A head packet leaves its queue only when the register stage of its port can take it. Packets are never dropped or copied. A full queue pushes back on its sender.

Top module: `tsw_switch`

## Requirements
- R1: After a synchronous reset, both `outValid` bits are 0 and both `inReady` bits are 1, because all queues are empty.
- R2: A packet whose address bit `ROUTE_BIT` is 0 leaves on output 0. A packet whose address bit `ROUTE_BIT` is 1 leaves on output 1. Address and payload are delivered unchanged.
- R3: Each input queue holds up to `DEPTH` packets. While a queue is full its `inReady` is 0, and nothing is taken from that input.
- R4: Every accepted packet is delivered exactly once. Packets from one input that go to one output keep their order.
- R5: When both queue heads target the same output and that output can take a packet, the head of the queue with the higher occupancy is forwarded first.
- R6: When both contending queues hold the same number of packets, input 0 is forwarded.
- R7: While an output has valid high and ready low, its valid, address and payload stay unchanged.
- R8: A packet accepted into an empty queue, whose output stage is free, becomes valid on its output one clock after the edge that accepted it, and not before.
- R9: Two head packets that target different outputs are both forwarded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 2 | Per-input packet valid |
| inReady | output | 2 | Per-input queue not full |
| inAddr | input | 2 x ADDR_W | Per-input destination address |
| inData | input | 2 x DATA_W | Per-input payload |
| outValid | output | 2 | Per-output packet valid (registered) |
| outReady | input | 2 | Per-output downstream ready |
| outAddr | output | 2 x ADDR_W | Per-output destination address |
| outData | output | 2 x DATA_W | Per-output payload |

## Verification
A queue can take a new packet on the same edge that its head is forwarded. The arbiter's occupancy comparison must then see a count that does not move, even though the queue contents change. The random phase provokes this by sending on both inputs while the output ready lines toggle, which forces frequent simultaneous push and pop. A scoreboard keyed by input and output judges the result: every delivered packet must match the oldest outstanding one for its pair, and all pairs must drain empty. A directed run with preloaded queues of 2 and 3 packets pins down the exact grant order that follows, including both tie cases.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int NPORT = 2;

  // strobes from control to datapath, one bit per port
  typedef struct packed {
    logic [NPORT-1:0] pop;   // dequeue head of input i
    logic [NPORT-1:0] load;  // capture into output register o
    logic [NPORT-1:0] sel;   // source input feeding output o
  } tsw_strobe_t;
endpackage

// File: rtl/tsw_fifo.sv
module tsw_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           inValid,
  output logic                           inReady,
  input  logic [WIDTH-1:0]               inFlit,
  input  logic                           pop,
  output logic                           headValid,
  output logic [WIDTH-1:0]               headFlit,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             push;

  assign inReady   = (count != FULL);
  assign push      = inValid && inReady;
  assign headValid = (count != '0);
  assign headFlit  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= inFlit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R3: a full queue with nothing leaving stays full (no hidden write)
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && !pop) |=> (count == FULL));

  // R4: control never dequeues from an empty queue
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    pop |-> headValid);
endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DEPTH     = 4,
  parameter int ROUTE_BIT = 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NPORT-1:0]                       headValid,
  input  logic [NPORT-1:0][ADDR_W-1:0]           headAddr,
  input  logic [NPORT-1:0][$clog2(DEPTH+1)-1:0]  count,
  input  logic [NPORT-1:0]                       outValid,
  input  logic [NPORT-1:0]                       outReady,
  output tsw_strobe_t                            strobe
);
  logic [NPORT-1:0][NPORT-1:0] req;   // req[o][i]
  logic [NPORT-1:0]            pickHi, freeSlot, loadV, popV;

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    for (genvar i = 0; i < NPORT; i++) begin : g_in
      assign req[o][i] = headValid[i] && (headAddr[i][ROUTE_BIT] == 1'(o));
    end
    // fuller queue wins; equal counts fall to input 0
    assign pickHi[o]   = req[o][1] && (!req[o][0] || (count[1] > count[0]));
    assign freeSlot[o] = !outValid[o] || outReady[o];
    assign loadV[o]    = (|req[o]) && freeSlot[o];

    // R2: whatever is loaded into output o carries route bit o
    p_route_r2: assert property (@(posedge clk) disable iff (rst)
      loadV[o] |-> (headAddr[pickHi[o]][ROUTE_BIT] == 1'(o)));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_pop
    assign popV[i] = (loadV[0] && (pickHi[0] == 1'(i))) ||
                     (loadV[1] && (pickHi[1] == 1'(i)));
  end

  assign strobe = '{pop: popV, load: loadV, sel: pickHi};
endmodule

// File: rtl/tsw_datapath.sv
module tsw_datapath
  import tsw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NPORT-1:0]                       inValid,
  output logic [NPORT-1:0]                       inReady,
  input  logic [NPORT-1:0][ADDR_W-1:0]           inAddr,
  input  logic [NPORT-1:0][DATA_W-1:0]           inData,
  input  tsw_strobe_t                            strobe,
  output logic [NPORT-1:0]                       headValid,
  output logic [NPORT-1:0][ADDR_W-1:0]           headAddr,
  output logic [NPORT-1:0][$clog2(DEPTH+1)-1:0]  count,
  input  logic [NPORT-1:0]                       outReady,
  output logic [NPORT-1:0]                       outValid,
  output logic [NPORT-1:0][ADDR_W-1:0]           outAddr,
  output logic [NPORT-1:0][DATA_W-1:0]           outData
);
  localparam int FLIT_W = ADDR_W + DATA_W;

  logic [NPORT-1:0][DATA_W-1:0] headData;

  for (genvar i = 0; i < NPORT; i++) begin : g_queue
    logic [FLIT_W-1:0] headFlit;
    tsw_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .inValid  (inValid[i]),
      .inReady  (inReady[i]),
      .inFlit   ({inAddr[i], inData[i]}),
      .pop      (strobe.pop[i]),
      .headValid(headValid[i]),
      .headFlit (headFlit),
      .count    (count[i])
    );
    assign headAddr[i] = headFlit[FLIT_W-1:DATA_W];
    assign headData[i] = headFlit[DATA_W-1:0];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_outReg
    always_ff @(posedge clk) begin
      if (rst)                  outValid[o] <= 1'b0;
      else if (strobe.load[o])  outValid[o] <= 1'b1;
      else if (outReady[o])     outValid[o] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (strobe.load[o]) begin
        outAddr[o] <= headAddr[strobe.sel[o]];
        outData[o] <= headData[strobe.sel[o]];
      end
    end

    // R7: a stalled output keeps its packet
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (outValid[o] && !outReady[o]) |=>
        (outValid[o] && $stable(outAddr[o]) && $stable(outData[o])));
  end
endmodule

// File: rtl/tsw_switch.sv
module tsw_switch
  import tsw_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int ROUTE_BIT = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    inValid,
  output logic [1:0]                    inReady,
  input  logic [1:0][ADDR_W-1:0]        inAddr,
  input  logic [1:0][DATA_W-1:0]        inData,
  output logic [1:0]                    outValid,
  input  logic [1:0]                    outReady,
  output logic [1:0][ADDR_W-1:0]        outAddr,
  output logic [1:0][DATA_W-1:0]        outData
);
  localparam int CNT_W = $clog2(DEPTH+1);

  tsw_strobe_t                   strobe;
  logic [NPORT-1:0]              headValid;
  logic [NPORT-1:0][ADDR_W-1:0]  headAddr;
  logic [NPORT-1:0][CNT_W-1:0]   count;

  tsw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .inAddr   (inAddr),
    .inData   (inData),
    .strobe   (strobe),
    .headValid(headValid),
    .headAddr (headAddr),
    .count    (count),
    .outReady (outReady),
    .outValid (outValid),
    .outAddr  (outAddr),
    .outData  (outData)
  );

  tsw_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ROUTE_BIT(ROUTE_BIT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .headValid(headValid),
    .headAddr (headAddr),
    .count    (count),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );
endmodule

// File: tb/tsw_switch_bench.sv
`timescale 1ns/1ps
module tsw_switch_bench;
  localparam int AW = 4, DW = 8, DEPTH = 4, RB = 1;
  localparam int FW = AW + DW;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]         inValid, inReady, outValid, outReady;
  logic [1:0][AW-1:0] inAddr, outAddr;
  logic [1:0][DW-1:0] inData, outData;

  tsw_switch #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .ROUTE_BIT(RB)) u_tsw_switch (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outAddr(outAddr), .outData(outData)
  );

  int nChecks = 0, nFail = 0, sentCount = 0, recvCount = 0;
  logic [FW-1:0] sb [4][$];     // index 2*src + out
  int            arbQ[$];       // expected source order on output 0
  logic [6:0]    seqCnt [2];
  bit            done0, done1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic logic [AW-1:0] mkAddr(input int o);
    logic [AW-1:0] a;
    a = AW'($urandom);
    a[RB] = o[0];
    return a;
  endfunction

  // caller stands just after a negedge
  task automatic send(input int p, input int o);
    logic [FW-1:0] f;
    f = {mkAddr(o), p[0], seqCnt[p]};
    seqCnt[p] = seqCnt[p] + 7'd1;
    inValid[p] = 1'b1;
    inAddr[p]  = f[FW-1:DW];
    inData[p]  = f[DW-1:0];
    while (!inReady[p]) @(negedge clk);
    sb[2*p+o].push_back(f);
    sentCount++;
    @(negedge clk);
    inValid[p] = 1'b0;
  endtask

  // monitor: a transfer happens at the next posedge when valid && ready
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      for (int o = 0; o < 2; o++) begin
        if (outValid[o] && outReady[o]) begin
          int src;
          int idx;
          src = int'(outData[o][DW-1]);
          idx = 2*src + o;
          recvCount++;
          check(outAddr[o][RB] == o[0], "R2", "route bit on output", int'(outAddr[o][RB]), o);
          if (sb[idx].size() == 0) begin
            check(1'b0, "R4", "unexpected packet", int'(outData[o]), -1);
          end else begin
            logic [FW-1:0] e;
            e = sb[idx].pop_front();
            check({outAddr[o], outData[o]} == e, "R4", "packet order/content",
                  int'({outAddr[o], outData[o]}), int'(e));
          end
          if (o == 0 && arbQ.size() > 0) begin
            int es;
            es = arbQ.pop_front();
            check(src == es, "R5 R6", "grant source", src, es);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    inValid = '0; inAddr = '0; inData = '0; outReady = '0;
    seqCnt[0] = '0; seqCnt[1] = '0;
    repeat (3) @(negedge clk);
    check(outValid == 2'b00, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady == 2'b11, "R1", "inReady after reset", int'(inReady), 3);
    rst = 1'b0;

    // R8 latency
    outReady = 2'b11;
    @(negedge clk);
    inValid[1] = 1'b1; inAddr[1] = mkAddr(0); inData[1] = {1'b1, seqCnt[1]};
    sb[2].push_back({inAddr[1], inData[1]}); sentCount++;
    seqCnt[1] = seqCnt[1] + 7'd1;
    @(negedge clk); inValid[1] = 1'b0; #1;
    check(outValid[0] == 1'b0, "R8", "valid too early", int'(outValid[0]), 0);
    @(negedge clk); #1;
    check(outValid[0] == 1'b1, "R8", "valid one clock after accept", int'(outValid[0]), 1);
    repeat (3) @(negedge clk);

    // R9 parallel forwarding
    inValid = 2'b11;
    inAddr[0] = mkAddr(1); inData[0] = {1'b0, seqCnt[0]};
    inAddr[1] = mkAddr(0); inData[1] = {1'b1, seqCnt[1]};
    sb[1].push_back({inAddr[0], inData[0]});
    sb[2].push_back({inAddr[1], inData[1]});
    sentCount += 2;
    seqCnt[0] = seqCnt[0] + 7'd1; seqCnt[1] = seqCnt[1] + 7'd1;
    @(negedge clk); inValid = 2'b00;
    @(negedge clk); #1;
    check(outValid == 2'b11, "R9", "both outputs valid together", int'(outValid), 3);
    repeat (3) @(negedge clk);

    // R5/R6 arbitration: block output 0, preload queues 2 and 3
    outReady[0] = 1'b0;
    send(0, 0);
    send(0, 0); send(0, 0);
    send(1, 0); send(1, 0); send(1, 0);
    repeat (2) @(negedge clk);
    arbQ = '{0, 1, 0, 1, 0, 1};
    outReady[0] = 1'b1;
    repeat (10) @(negedge clk);
    check(arbQ.size() == 0, "R5", "all arbitration grants seen", arbQ.size(), 0);

    // R3 full queue backpressure; R7 hold while stalled
    outReady[1] = 1'b0;
    repeat (5) send(0, 1);
    #1;
    check(inReady[0] == 1'b0, "R3", "inReady low when full", int'(inReady[0]), 0);
    check(inReady[1] == 1'b1, "R3", "other input still ready", int'(inReady[1]), 1);
    fork
      send(0, 1);
      begin
        repeat (3) @(negedge clk);
        check(inReady[0] == 1'b0, "R3", "still full while stalled", int'(inReady[0]), 0);
        check(outValid[1] && ({outAddr[1], outData[1]} == sb[1][0]), "R7",
              "stalled output holds oldest", int'({outAddr[1], outData[1]}), int'(sb[1][0]));
        outReady[1] = 1'b1;
      end
    join
    repeat (10) @(negedge clk);

    // random traffic with toggling ready (R4, simultaneous push/pop)
    done0 = 1'b0; done1 = 1'b0;
    fork
      begin for (int k = 0; k < 40; k++) send(0, int'($urandom_range(1))); done0 = 1'b1; end
      begin for (int k = 0; k < 40; k++) send(1, int'($urandom_range(1))); done1 = 1'b1; end
      begin
        while (!(done0 && done1)) begin
          @(negedge clk);
          outReady = 2'($urandom);
        end
      end
    join
    outReady = 2'b11;
    repeat (15) @(negedge clk);
    for (int q = 0; q < 4; q++)
      check(sb[q].size() == 0, "R4", "scoreboard drained", sb[q].size(), 0);
    check(recvCount == sentCount, "R4", "delivered count", recvCount, sentCount);
    finishRun();
  end
endmodule